// File: doc/BRIEF.md
# Interval Timer Byte-Wide Register Sequencer

This block is the byte-wide programming front end of a three-channel interval timer. A host reaches it through a 2-bit address, an 8-bit write bus with a write strobe and an 8-bit read bus with a read strobe. Address 3 takes control words. Addresses 0, 1 and 2 are the data ports of the three channels. Each channel keeps a 16-bit count. The host can only reach that count one byte at a time, so the block keeps a small byte-order state for every channel.

A control word selects a channel, and for that channel it sets the operating mode, the BCD flag and one of three byte-access orders: low byte only, high byte only, or low then high. It can instead carry a latch command. A latch freezes a copy of the running count, and the next two reads return that copy. Data writes are assembled into 16-bit values, which are handed to the channel with a one-cycle load strobe. Reads are served from the live count, or from the frozen copy while one is pending. A minimal counter is instantiated per channel so that reads have something to return. It loads on the strobe and steps down on a tick input while its gate is high. Its finer timing behaviour is not part of this block.

Top module: `tmr_regif`

## Requirements
- R1: After reset, every channel has mode 3, BCD flag 0, low-byte-only access and count 0. The gates of channels 0 and 1 are high and the gate of channel 2 is low.
- R2: A write to address 3 is a control word. Bits 7:6 select the channel, and the value 3 in that field makes the whole word have no effect. Bits 5:4 give the access: 0 = latch, 1 = low byte only, 2 = high byte only, 3 = low then high. For a non-latch access, bits 3:1 become the channel mode, bit 0 becomes the BCD flag, and the byte order restarts at the low byte. Mode and BCD change only on such a word.
- R3: With low-byte-only access, a data write loads the count {8'h00, byte}. With high-byte-only access, it loads {byte, 8'h00}. A load shows as a pulse on `ld_pulse[channel]` with the value on `ld_value`, in the same cycle as the write strobe.
- R4: With low-then-high access, the first data write is held with no load. The second write loads {second byte, first byte}, and the order then repeats.
- R5: Without a pending latch, a read returns count bits 7:0 for low-byte-only access and bits 15:8 for high-byte-only access. For low-then-high access, reads alternate low, high, low, and so on. This alternation shares its position with data writes.
- R6: A latch command copies the channel's count as it stands in that cycle, and leaves mode, BCD and access unchanged. The next two reads of that channel return the copy's low byte and then its high byte, whatever the count does in the meantime.
- R7: Once both bytes of a copy have been read, reads of that channel again follow its programmed access on the live count.
- R8: A latch command for a channel whose copy has not been fully read has no effect.
- R9: A read of address 3 returns 0 and changes no state. `rdata` is 0 whenever the read strobe is low. A cycle that has both strobes is handled as a write only.
- R10: The count steps down by 1, modulo 2^16, on each cycle with `tick` high and the channel's gate high. A load takes priority over a step. `gate_we` copies `gate_in` into the three gates.
- R11: A control word never produces a load. At most one channel loads per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address: 0-2 channel data, 3 control |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data byte, valid in the strobe cycle |
| tick | input | 1 | Count step enable for all channels |
| gate_we | input | 1 | Gate update strobe |
| gate_in | input | 3 | New gate levels, bit i for channel i |
| ld_pulse | output | 3 | Load strobe, bit i for channel i |
| ld_value | output | 16 | Value being loaded, 0 when no load |
| ch_mode | output | 9 | Mode per channel, bits 3i+2:3i for channel i |
| ch_bcd | output | 3 | BCD flag per channel |
| ch_gate | output | 3 | Gate level per channel |

## Verification
The bound checker watches, on every cycle, the properties that need no memory of the byte order. These are: control words never load, at most one load strobe fires and it belongs to the addressed channel, read data is zero at address 3 and when no read is strobed, a control word aimed at channel 3 changes nothing, mode only moves on control writes, and gates only move on a gate strobe. How a byte write combines with an earlier held byte, which half of the count a read returns, and when a frozen copy is released or a second latch is dropped, all depend on earlier traffic. Only the bench's scenarios can show these. It compares every cycle against a model built from the requirements.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;
    localparam int NUM_CH = 3;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(3);
    localparam logic [1:0]        NO_CHAN   = 2'd3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    // Field order follows the bit layout of the control byte.
    typedef struct packed {
        logic [1:0]        sel;
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } ctl_word_t;

    typedef struct packed {
        acc_e              acc;
        logic              hi_next;
        logic [BYTE_W-1:0] lo_hold;
        logic              held;
        logic              held_hi;
        logic [CNT_W-1:0]  snap;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } port_state_t;

    function automatic ctl_word_t decode_ctl(input logic [BYTE_W-1:0] b);
        return ctl_word_t'(b);
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] v,
                                                    input logic hi);
        return hi ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/tmr_ctrl_dec.sv
module tmr_ctrl_dec
    import tmr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NUM_CH-1:0] cfg_we,
    output logic [NUM_CH-1:0] latch_req,
    output logic [NUM_CH-1:0] data_we,
    output logic [NUM_CH-1:0] data_re,
    output ctl_word_t         ctl
);
    logic ctrl_wr;

    always_comb begin
        ctl     = decode_ctl(wdata);
        ctrl_wr = wr_en && (addr == CTRL_ADDR) && (ctl.sel != NO_CHAN);
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        always_comb begin
            cfg_we[i]    = ctrl_wr && (int'(ctl.sel) == i) && (ctl.acc != ACC_LATCH);
            latch_req[i] = ctrl_wr && (int'(ctl.sel) == i) && (ctl.acc == ACC_LATCH);
            data_we[i]   = wr_en && (int'(addr) == i);
            data_re[i]   = rd_en && !wr_en && (int'(addr) == i);
        end
    end
endmodule

// File: rtl/tmr_chport.sv
module tmr_chport
    import tmr_pkg::*;
#(
    parameter logic [MODE_W-1:0] MODE_RST = MODE_W'(3)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  ctl_word_t         ctl,
    input  logic              latch_req,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic [BYTE_W-1:0] rbyte,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val,
    output logic [MODE_W-1:0] mode,
    output logic              bcd
);
    port_state_t st;

    always_comb begin
        load_stb = 1'b0;
        load_val = '0;
        if (data_we) begin
            unique case (st.acc)
                ACC_LO: begin
                    load_stb = 1'b1;
                    load_val = {{BYTE_W{1'b0}}, wbyte};
                end
                ACC_HI: begin
                    load_stb = 1'b1;
                    load_val = {wbyte, {BYTE_W{1'b0}}};
                end
                ACC_WORD: begin
                    load_stb = st.hi_next;
                    load_val = st.hi_next ? {wbyte, st.lo_hold} : '0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        if (st.held) begin
            rbyte = pick_byte(st.snap, st.held_hi);
        end else begin
            unique case (st.acc)
                ACC_HI:   rbyte = pick_byte(live_cnt, 1'b1);
                ACC_WORD: rbyte = pick_byte(live_cnt, st.hi_next);
                default:  rbyte = pick_byte(live_cnt, 1'b0);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= '0;
            st.acc     <= ACC_LO;
            st.mode    <= MODE_RST;
        end else if (cfg_we) begin
            st.acc     <= ctl.acc;
            st.mode    <= ctl.mode;
            st.bcd     <= ctl.bcd;
            st.hi_next <= 1'b0;
            st.held    <= 1'b0;
            st.held_hi <= 1'b0;
        end else if (latch_req) begin
            if (!st.held) begin
                st.snap    <= live_cnt;
                st.held    <= 1'b1;
                st.held_hi <= 1'b0;
            end
        end else if (data_we) begin
            if (st.acc == ACC_WORD) begin
                if (!st.hi_next) st.lo_hold <= wbyte;
                st.hi_next <= ~st.hi_next;
            end
        end else if (data_re) begin
            if (st.held) begin
                if (st.held_hi) begin
                    st.held    <= 1'b0;
                    st.held_hi <= 1'b0;
                end else begin
                    st.held_hi <= 1'b1;
                end
            end else if (st.acc == ACC_WORD) begin
                st.hi_next <= ~st.hi_next;
            end
        end
    end

    assign mode = st.mode;
    assign bcd  = st.bcd;
endmodule

// File: rtl/tmr_chcount.sv
module tmr_chcount
    import tmr_pkg::*;
#(
    parameter logic GATE_RST = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             gate_we,
    input  logic             gate_in,
    output logic [CNT_W-1:0] cnt,
    output logic             gate
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            gate <= GATE_RST;
        end else begin
            if (load_stb)          cnt <= load_val;
            else if (tick && gate) cnt <= cnt - CNT_W'(1);
            if (gate_we)           gate <= gate_in;
        end
    end
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter logic [NUM_CH-1:0] GATE_RST = 3'b011,
    parameter logic [MODE_W-1:0] MODE_RST = MODE_W'(3)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wr_en,
    input  logic [BYTE_W-1:0]        wdata,
    input  logic                     rd_en,
    output logic [BYTE_W-1:0]        rdata,
    input  logic                     tick,
    input  logic                     gate_we,
    input  logic [NUM_CH-1:0]        gate_in,
    output logic [NUM_CH-1:0]        ld_pulse,
    output logic [CNT_W-1:0]         ld_value,
    output logic [NUM_CH*MODE_W-1:0] ch_mode,
    output logic [NUM_CH-1:0]        ch_bcd,
    output logic [NUM_CH-1:0]        ch_gate
);
    logic [NUM_CH-1:0] cfg_we, latch_req, data_we, data_re;
    ctl_word_t         ctl;
    logic [BYTE_W-1:0] rbyte    [NUM_CH];
    logic [CNT_W-1:0]  load_val [NUM_CH];
    logic [CNT_W-1:0]  live     [NUM_CH];

    tmr_ctrl_dec u_dec (
        .addr      (addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wdata     (wdata),
        .cfg_we    (cfg_we),
        .latch_req (latch_req),
        .data_we   (data_we),
        .data_re   (data_re),
        .ctl       (ctl)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tmr_chport #(.MODE_RST(MODE_RST)) u_port (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (cfg_we[i]),
            .ctl       (ctl),
            .latch_req (latch_req[i]),
            .data_we   (data_we[i]),
            .data_re   (data_re[i]),
            .wbyte     (wdata),
            .live_cnt  (live[i]),
            .rbyte     (rbyte[i]),
            .load_stb  (ld_pulse[i]),
            .load_val  (load_val[i]),
            .mode      (ch_mode[i*MODE_W +: MODE_W]),
            .bcd       (ch_bcd[i])
        );

        tmr_chcount #(.GATE_RST(GATE_RST[i])) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .load_stb (ld_pulse[i]),
            .load_val (load_val[i]),
            .tick     (tick),
            .gate_we  (gate_we),
            .gate_in  (gate_in[i]),
            .cnt      (live[i]),
            .gate     (ch_gate[i])
        );
    end

    always_comb begin
        ld_value = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ld_pulse[i]) ld_value = ld_value | load_val[i];
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en && !wr_en && addr != CTRL_ADDR) rdata = rbyte[addr];
    end
endmodule

// File: rtl/tmr_regif_chk.sv
module tmr_regif_chk
    import tmr_pkg::*;
#(
    parameter logic [NUM_CH-1:0] GATE_RST = 3'b011,
    parameter logic [MODE_W-1:0] MODE_RST = MODE_W'(3)
) (
    input logic                     clk,
    input logic                     rst,
    input logic [ADDR_W-1:0]        addr,
    input logic                     wr_en,
    input logic [BYTE_W-1:0]        wdata,
    input logic                     rd_en,
    input logic [BYTE_W-1:0]        rdata,
    input logic                     tick,
    input logic                     gate_we,
    input logic [NUM_CH-1:0]        gate_in,
    input logic [NUM_CH-1:0]        ld_pulse,
    input logic [CNT_W-1:0]         ld_value,
    input logic [NUM_CH*MODE_W-1:0] ch_mode,
    input logic [NUM_CH-1:0]        ch_bcd,
    input logic [NUM_CH-1:0]        ch_gate
);
    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (ch_mode == {NUM_CH{MODE_RST}}) && (ch_bcd == '0) && (ch_gate == GATE_RST)); // R1

    AST_CH3_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == CTRL_ADDR && wdata[7:6] == NO_CHAN) |=> ($stable(ch_mode) && $stable(ch_bcd))); // R2

    AST_MODE_ONLY_CTRL: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == CTRL_ADDR) |=> ($stable(ch_mode) && $stable(ch_bcd))); // R2

    AST_LOAD_AT_PORT: assert property (@(posedge clk) disable iff (rst)
        (ld_pulse != '0) |-> (wr_en && addr != CTRL_ADDR && ld_pulse[addr])); // R3

    AST_CTRL_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == CTRL_ADDR) |-> (ld_pulse == '0)); // R11

    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ld_pulse)); // R11

    AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && addr == CTRL_ADDR) |-> (rdata == '0)); // R9

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == '0)); // R9

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !gate_we |=> $stable(ch_gate)); // R10
endmodule

bind tmr_regif tmr_regif_chk #(.GATE_RST(GATE_RST), .MODE_RST(MODE_RST)) u_chk (.*);

// File: tb/tmr_regif_tb.sv
module tmr_regif_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0, gate_we = 1'b0;
    logic [7:0] wdata = '0;
    logic [2:0] gate_in = '0;
    logic [7:0] rdata;
    logic [2:0] ld_pulse, ch_bcd, ch_gate;
    logic [15:0] ld_value;
    logic [8:0] ch_mode;

    int n_chk = 0;
    int n_err = 0;
    bit first_cyc = 1'b1;
    string force_tag = "";

    // Requirement-level model
    logic [15:0] m_cnt [3];
    logic [15:0] m_snap[3];
    logic [7:0]  m_lo  [3];
    logic [1:0]  m_acc [3];
    logic [2:0]  m_mode[3];
    bit m_bcd[3], m_hi[3], m_held[3], m_hh[3], m_post[3];
    logic [2:0]  m_gate;

    tmr_regif u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .tick(tick), .gate_we(gate_we),
        .gate_in(gate_in), .ld_pulse(ld_pulse), .ld_value(ld_value),
        .ch_mode(ch_mode), .ch_bcd(ch_bcd), .ch_gate(ch_gate)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not finish, act=hung exp=done");
        summary();
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: act=%h exp=%h", (force_tag != "") ? force_tag : tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int c = 0; c < 3; c++) begin
            m_cnt[c] = '0; m_snap[c] = '0; m_lo[c] = '0; m_acc[c] = 2'd1;
            m_mode[c] = 3'd3; m_bcd[c] = 0; m_hi[c] = 0; m_held[c] = 0;
            m_hh[c] = 0; m_post[c] = 0;
        end
        m_gate = 3'b011;
    endfunction

    task automatic cyc(bit w, bit r, logic [1:0] a, logic [7:0] d, bit tk, bit gw, logic [2:0] gi);
        logic [7:0]  e_rd;
        logic [2:0]  e_pl;
        logic [15:0] e_val;
        string rtag, ptag;
        int c;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; tick = tk; gate_we = gw; gate_in = gi;
        #1;
        c = int'(a);
        // expected read byte
        e_rd = '0; rtag = "R9";
        if (r && !w && a != 2'd3) begin
            if (m_held[c]) begin
                e_rd = m_hh[c] ? m_snap[c][15:8] : m_snap[c][7:0];
                rtag = "R6";
            end else begin
                case (m_acc[c])
                    2'd2:    e_rd = m_cnt[c][15:8];
                    2'd3:    e_rd = m_hi[c] ? m_cnt[c][15:8] : m_cnt[c][7:0];
                    default: e_rd = m_cnt[c][7:0];
                endcase
                rtag = m_post[c] ? "R7" : "R5";
            end
        end
        // expected load
        e_pl = '0; e_val = '0; ptag = "R11";
        if (w && a != 2'd3) begin
            ptag = (m_acc[c] == 2'd3) ? "R4" : "R3";
            case (m_acc[c])
                2'd1: begin e_pl[c] = 1'b1; e_val = {8'h00, d}; end
                2'd2: begin e_pl[c] = 1'b1; e_val = {d, 8'h00}; end
                2'd3: if (m_hi[c]) begin e_pl[c] = 1'b1; e_val = {d, m_lo[c]}; end
                default: ;
            endcase
        end
        chk(rtag, 32'(rdata), 32'(e_rd));
        chk(ptag, 32'(ld_pulse), 32'(e_pl));
        chk(ptag, 32'(ld_value), 32'(e_val));
        chk(first_cyc ? "R1" : "R2", 32'(ch_mode), 32'({m_mode[2], m_mode[1], m_mode[0]}));
        chk(first_cyc ? "R1" : "R2", 32'(ch_bcd), 32'({m_bcd[2], m_bcd[1], m_bcd[0]}));
        chk(first_cyc ? "R1" : "R10", 32'(ch_gate), 32'(m_gate));
        first_cyc = 1'b0;
        // model update
        if (w && a == 2'd3) begin
            int s = int'(d[7:6]);
            if (s != 3) begin
                if (d[5:4] == 2'd0) begin
                    if (!m_held[s]) begin   // R8: a second latch is dropped
                        m_snap[s] = m_cnt[s]; m_held[s] = 1; m_hh[s] = 0;
                    end
                end else begin
                    m_acc[s] = d[5:4]; m_mode[s] = d[3:1]; m_bcd[s] = d[0];
                    m_hi[s] = 0; m_held[s] = 0; m_hh[s] = 0; m_post[s] = 0;
                end
            end
        end else if (w) begin
            if (m_acc[c] == 2'd3) begin
                if (!m_hi[c]) m_lo[c] = d;
                m_hi[c] = !m_hi[c];
            end
        end else if (r && a != 2'd3) begin
            if (m_held[c]) begin
                if (m_hh[c]) begin m_held[c] = 0; m_hh[c] = 0; m_post[c] = 1; end
                else m_hh[c] = 1;
            end else if (m_acc[c] == 2'd3) begin
                m_hi[c] = !m_hi[c];
            end
        end
        for (int k = 0; k < 3; k++) begin
            if (e_pl[k]) m_cnt[k] = e_val;
            else if (tk && m_gate[k]) m_cnt[k] = m_cnt[k] - 16'd1;
        end
        if (gw) m_gate = gi;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d, bit tk = 0);
        cyc(1, 0, a, d, tk, 0, 3'b000);
    endtask

    task automatic rd(logic [1:0] a, bit tk = 0);
        cyc(0, 1, a, 8'h00, tk, 0, 3'b000);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, ch0 reads count 0 low byte
        rd(2'd0);
        // R2/R4: ch0 low-then-high, mode 2
        wr(2'd3, 8'b00_11_010_0);
        wr(2'd0, 8'hCD);
        wr(2'd0, 8'hAB);
        // R5: alternate low/high reads
        rd(2'd0); rd(2'd0);
        // R6: latch then let count move, snapshot returned
        wr(2'd3, 8'b00_00_000_0);
        cyc(0, 0, 2'd0, 8'h00, 1, 0, 3'b000);
        cyc(0, 0, 2'd0, 8'h00, 1, 0, 3'b000);
        rd(2'd0, 1); rd(2'd0, 1);
        // R7: after snapshot drained, live value again
        rd(2'd0); rd(2'd0);
        // R8: second latch while pending is ignored
        wr(2'd3, 8'b00_00_000_0);
        cyc(0, 0, 2'd0, 8'h00, 1, 0, 3'b000);
        force_tag = "R8";
        wr(2'd3, 8'b00_00_000_0, 1);
        rd(2'd0, 1); rd(2'd0);
        force_tag = "";
        // R2: channel field 3 ignored
        wr(2'd3, 8'b11_01_101_1);
        rd(2'd1);
        // R3: ch1 low only, ch2 high only
        wr(2'd3, 8'b01_01_100_1);
        wr(2'd1, 8'h5A);
        rd(2'd1);
        wr(2'd3, 8'b10_10_001_0);
        wr(2'd2, 8'h12);
        rd(2'd2);
        // R10: ch2 gate low holds; open gate, then count steps
        cyc(0, 0, 2'd0, 8'h00, 1, 0, 3'b000);
        cyc(0, 0, 2'd0, 8'h00, 0, 1, 3'b111);
        cyc(0, 0, 2'd0, 8'h00, 1, 0, 3'b000);
        rd(2'd2);
        // R10: load beats tick on same cycle
        wr(2'd1, 8'h07, 1);
        rd(2'd1);
        // R9: control read returns zero; both strobes count as write
        rd(2'd3);
        cyc(1, 1, 2'd1, 8'h33, 0, 0, 3'b000);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            int op = int'($urandom % 10);
            bit tk = 1'($urandom % 2);
            bit gw = ($urandom % 16) == 0;
            logic [2:0] gi = 3'($urandom);
            logic [7:0] d  = 8'($urandom);
            if (op < 3)      cyc(1, 0, 2'd3, d, tk, gw, gi);
            else if (op < 6) cyc(1, 0, 2'($urandom % 3), d, tk, gw, gi);
            else if (op < 9) cyc(0, 1, 2'($urandom % 4), 8'h00, tk, gw, gi);
            else             cyc(0, 0, 2'd0, 8'h00, tk, gw, gi);
        end
        @(negedge clk);
        wr_en = 0; rd_en = 0; tick = 0; gate_we = 0;
        summary();
    end
endmodule